// File: doc/BRIEF.md
# Modem Status and Interrupt Register

This block holds the status byte that a host microcontroller reads from a packet data modem, and drives the interrupt request line that tells the host to read it. It watches four things: task codes written to the command register, the mode select bits, the host's read strobe, and single-cycle event pulses from the modem datapath. The datapath pulses cover frame sync detection, a late receive task, task completion with its CRC verdict, status symbol traffic, and the symbol-period tick.

Each flag has its own set sources, its own clear sources and its own meaning in each mode. Bit 5 reports a free transmit buffer while transmitting. While receiving, the same bit reports an autonomous frame sync hit. Some flags clear when the host reads the byte and some survive a read. Writing a RESET task, or changing the transmit/receive, zero-power or power-save mode bits, flushes the block. A flush clears the receive flags and marks the transmit buffer as free without raising an interrupt.

Command byte layout: bit 7 enables autonomous frame sync and bits 6:0 carry the task code. The codes are NULL = 0, RESET = 1, sync search = 2, and any other value is a working task.

Top module: `modem_status`

## Requirements
- R1: In transmit mode, status bit 5 reads 1 on the cycle after a RESET task write or a change of any of the transmit, zero-power or power-save mode bits. This set does not raise IRQ, and a status read does not clear bit 5 in transmit mode.
- R2: In transmit mode, a command write whose task code is neither NULL (0) nor RESET (1) clears bit 5 on the first `sym_tick` after the write cycle. A tick in the write cycle itself does not count. NULL and RESET writes never clear bit 5.
- R3: In receive mode, an `ev_sync` pulse sets bit 5 and bit 7 (IRQ) when the last command write had bit 7 set and no sync-search task (code 2) is active. A sync-search task is active from its write until `ev_done` or a flush. A status read clears bit 5.
- R4: In receive mode, `ev_late` sets bit 4 and IRQ. A read or a flush clears bit 4. In transmit mode, bit 4 reads 0 and `ev_late` has no effect.
- R5: In receive mode, `ev_done` loads `ev_crc_bad` into bit 3. A status read does not clear bit 3, but a flush does. In transmit mode, bit 3 reads 0 and `ev_done` has no effect.
- R6: `ev_sym` sets bit 2 in either mode. A read or a flush clears bit 2. When a set and a read fall in the same cycle, the set wins.
- R7: In receive mode, `ev_sym` loads bits 1:0. With `mode_4lvl` = 1 they take `ev_sym_val`; with `mode_4lvl` = 0 they take {0, `ev_sym_val[0]`}. In transmit mode, bits 1:0 read 0 and are not loaded.
- R8: `irq` equals status bit 7. A status read clears it unless an interrupt-raising event arrives in the same cycle. A flush also clears it.
- R9: After `rst`, all flags are 0 except the transmit buffer-free flag, so status reads 0x00 in receive mode and 0x20 in transmit mode. Bit 6 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd | input | 1 | Status read strobe; flags clear at the following edge |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_data | input | 8 | Command byte: bit 7 autonomous sync enable, bits 6:0 task code |
| mode_tx | input | 1 | 1 = transmit, 0 = receive |
| mode_zp | input | 1 | Zero-power mode bit |
| mode_psave | input | 1 | Power-save mode bit |
| mode_4lvl | input | 1 | 1 = 4-level symbol mode, 0 = binary mode |
| ev_sync | input | 1 | Frame sync detected pulse |
| ev_late | input | 1 | Receive task written too late pulse |
| ev_done | input | 1 | Task end (buffer free rising) pulse |
| ev_crc_bad | input | 1 | CRC verdict with ev_done, 1 = error |
| ev_sym | input | 1 | Status symbol received or sent pulse |
| ev_sym_val | input | 2 | Value of the status symbol |
| sym_tick | input | 1 | One pulse per symbol period |
| status | output | 8 | Status byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench targets same-cycle collisions. A read that meets an overflow or a symbol event must leave that flag visible, and a design that let the clear win would lose the event. It checks that a CRC error survives a read, which a design that cleared every flag on read would get wrong. It checks that a sync seen during a sync-search task leaves bit 5 alone, and that a flush raises no IRQ. A task write paired with a tick in the same cycle must not clear bit 5 early. A mode change between a task write and its tick must cancel the pending clear, and a design that kept it would empty the buffer-free flag after a flush.

// File: rtl/modem_status_pkg.sv
package modem_status_pkg;

    localparam int CMD_W     = 8;
    localparam int TASK_W    = CMD_W - 1;
    localparam int AUTO_BIT  = CMD_W - 1;
    localparam int SVAL_W    = 2;
    localparam int STAT_W    = 8;

    typedef logic [TASK_W-1:0] task_code_t;

    localparam task_code_t TASK_NULL   = task_code_t'(0);
    localparam task_code_t TASK_RESET  = task_code_t'(1);
    localparam task_code_t TASK_SEARCH = task_code_t'(2);

    typedef struct packed {
        logic tx;
        logic zp;
        logic psave;
    } mode_t;

    typedef struct packed {
        logic              irq;
        logic              sync;
        logic              ovf;
        logic              crc;
        logic              symrdy;
        logic [SVAL_W-1:0] sval;
    } rx_state_t;

    function automatic logic starts_work(task_code_t code);
        return (code != TASK_NULL) && (code != TASK_RESET);
    endfunction

    function automatic logic [SVAL_W-1:0] map_sym(logic four_level, logic [SVAL_W-1:0] v);
        return four_level ? v : {{(SVAL_W-1){1'b0}}, v[0]};
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(logic tx, logic txrdy, rx_state_t s);
        logic [STAT_W-1:0] b;
        b    = '0;
        b[7] = s.irq;
        b[5] = tx ? txrdy : s.sync;
        b[2] = s.symrdy;
        if (!tx) begin
            b[4]   = s.ovf;
            b[3]   = s.crc;
            b[1:0] = s.sval;
        end
        return b;
    endfunction

endpackage

// File: rtl/ms_cmd_track.sv
module ms_cmd_track
    import modem_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_data,
    input  mode_t            mode,
    input  logic             task_end,
    output logic             flush,
    output logic             work_wr,
    output logic             auto_sync,
    output logic             in_search
);

    task_code_t code;
    mode_t      mode_q;
    task_code_t active_q;

    assign code    = cmd_data[TASK_W-1:0];
    assign work_wr = cmd_wr && starts_work(code);
    assign flush   = (cmd_wr && code == TASK_RESET) || (mode != mode_q);

    always_ff @(posedge clk) begin
        mode_q <= mode;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            auto_sync <= 1'b0;
        end else if (cmd_wr) begin
            auto_sync <= cmd_data[AUTO_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            active_q <= TASK_NULL;
        end else if (work_wr) begin
            active_q <= code;
        end else if (task_end) begin
            active_q <= TASK_NULL;
        end
    end

    assign in_search = (active_q == TASK_SEARCH);

endmodule

// File: rtl/ms_tx_ready.sv
module ms_tx_ready (
    input  logic clk,
    input  logic rst,
    input  logic tx,
    input  logic flush,
    input  logic work_wr,
    input  logic tick,
    output logic txrdy
);

    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            txrdy  <= 1'b1;
            pend_q <= 1'b0;
        end else if (tx && work_wr) begin
            pend_q <= 1'b1;
        end else if (pend_q && tick) begin
            txrdy  <= 1'b0;
            pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/ms_rx_flags.sv
module ms_rx_flags
    import modem_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx,
    input  logic              four_level,
    input  logic              flush,
    input  logic              rd,
    input  logic              sync_hit,
    input  logic              late,
    input  logic              done,
    input  logic              crc_bad,
    input  logic              sym,
    input  logic [SVAL_W-1:0] sym_val,
    output rx_state_t         st
);

    rx_state_t nxt;

    always_comb begin
        nxt = st;
        if (rd) begin
            nxt.irq    = 1'b0;
            nxt.sync   = 1'b0;
            nxt.ovf    = 1'b0;
            nxt.symrdy = 1'b0;
        end
        if (!tx && sync_hit) begin
            nxt.sync = 1'b1;
            nxt.irq  = 1'b1;
        end
        if (!tx && late) begin
            nxt.ovf = 1'b1;
            nxt.irq = 1'b1;
        end
        if (!tx && done) begin
            nxt.crc = crc_bad;
        end
        if (sym) begin
            nxt.symrdy = 1'b1;
            if (!tx) begin
                nxt.sval = map_sym(four_level, sym_val);
            end
        end
        if (flush) begin
            nxt.irq    = 1'b0;
            nxt.sync   = 1'b0;
            nxt.ovf    = 1'b0;
            nxt.crc    = 1'b0;
            nxt.symrdy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st <= nxt;
        end
    end

endmodule

// File: rtl/modem_status.sv
module modem_status
    import modem_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_rd,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_data,
    input  logic              mode_tx,
    input  logic              mode_zp,
    input  logic              mode_psave,
    input  logic              mode_4lvl,
    input  logic              ev_sync,
    input  logic              ev_late,
    input  logic              ev_done,
    input  logic              ev_crc_bad,
    input  logic              ev_sym,
    input  logic [SVAL_W-1:0] ev_sym_val,
    input  logic              sym_tick,
    output logic [STAT_W-1:0] status,
    output logic              irq
);

    mode_t     mode;
    logic      flush;
    logic      work_wr;
    logic      auto_sync;
    logic      in_search;
    logic      txrdy;
    logic      sync_hit;
    rx_state_t rx_st;

    assign mode = '{tx: mode_tx, zp: mode_zp, psave: mode_psave};

    ms_cmd_track u_cmd (
        .clk       (clk),
        .rst       (rst),
        .cmd_wr    (cmd_wr),
        .cmd_data  (cmd_data),
        .mode      (mode),
        .task_end  (ev_done),
        .flush     (flush),
        .work_wr   (work_wr),
        .auto_sync (auto_sync),
        .in_search (in_search)
    );

    ms_tx_ready u_txr (
        .clk     (clk),
        .rst     (rst),
        .tx      (mode_tx),
        .flush   (flush),
        .work_wr (work_wr),
        .tick    (sym_tick),
        .txrdy   (txrdy)
    );

    assign sync_hit = ev_sync && auto_sync && !in_search;

    ms_rx_flags u_rx (
        .clk        (clk),
        .rst        (rst),
        .tx         (mode_tx),
        .four_level (mode_4lvl),
        .flush      (flush),
        .rd         (host_rd),
        .sync_hit   (sync_hit),
        .late       (ev_late),
        .done       (ev_done),
        .crc_bad    (ev_crc_bad),
        .sym        (ev_sym),
        .sym_val    (ev_sym_val),
        .st         (rx_st)
    );

    assign status = pack_status(mode_tx, txrdy, rx_st);
    assign irq    = rx_st.irq;

endmodule

// File: rtl/modem_status_chk.sv
module modem_status_chk
    import modem_status_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              host_rd,
    input logic              cmd_wr,
    input logic [CMD_W-1:0]  cmd_data,
    input logic              mode_tx,
    input logic              mode_zp,
    input logic              mode_psave,
    input logic              ev_sync,
    input logic              ev_late,
    input logic              ev_done,
    input logic              ev_sym,
    input logic [STAT_W-1:0] status,
    input logic              irq
);

    logic [2:0] mode_seen;
    logic       reset_wr;
    logic       flush_now;

    always_ff @(posedge clk) begin
        mode_seen <= {mode_tx, mode_zp, mode_psave};
    end

    assign reset_wr  = cmd_wr && (cmd_data[TASK_W-1:0] == TASK_RESET);
    assign flush_now = reset_wr || ({mode_tx, mode_zp, mode_psave} != mode_seen);

    assert_txset_R1: assert property (@(posedge clk) disable iff (rst)
        (mode_tx && reset_wr) |=> (!mode_tx || status[5]));

    assert_flush_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        reset_wr |=> !irq);

    assert_txrdy_source_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_tx && $past(mode_tx) && $rose(status[5])) |-> $past(flush_now));

    assert_ovf_set_R4: assert property (@(posedge clk) disable iff (rst)
        (!mode_tx && ev_late && !flush_now) |=> (irq && (mode_tx || status[4])));

    assert_tx_masks_R4: assert property (@(posedge clk) disable iff (rst)
        mode_tx |-> (status[4:3] == 2'b00));

    assert_crc_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !mode_tx && !ev_done && !flush_now) |=> (mode_tx || status[3] == $past(status[3])));

    assert_sym_set_R6: assert property (@(posedge clk) disable iff (rst)
        (ev_sym && !flush_now) |=> status[2]);

    assert_tx_sval_R7: assert property (@(posedge clk) disable iff (rst)
        mode_tx |-> (status[1:0] == 2'b00));

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !ev_late && !ev_sync) |=> !irq);

endmodule

bind modem_status modem_status_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .host_rd    (host_rd),
    .cmd_wr     (cmd_wr),
    .cmd_data   (cmd_data),
    .mode_tx    (mode_tx),
    .mode_zp    (mode_zp),
    .mode_psave (mode_psave),
    .ev_sync    (ev_sync),
    .ev_late    (ev_late),
    .ev_done    (ev_done),
    .ev_sym     (ev_sym),
    .status     (status),
    .irq        (irq)
);

// File: tb/modem_status_tb_top.sv
module modem_status_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       host_rd, cmd_wr;
    logic [7:0] cmd_data;
    logic       mode_tx, mode_zp, mode_psave, mode_4lvl;
    logic       ev_sync, ev_late, ev_done, ev_crc_bad, ev_sym;
    logic [1:0] ev_sym_val;
    logic       sym_tick;
    logic [7:0] status;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5ns clk = ~clk;

    modem_status dut_i (
        .clk(clk), .rst(rst), .host_rd(host_rd), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .mode_tx(mode_tx), .mode_zp(mode_zp), .mode_psave(mode_psave), .mode_4lvl(mode_4lvl),
        .ev_sync(ev_sync), .ev_late(ev_late), .ev_done(ev_done), .ev_crc_bad(ev_crc_bad),
        .ev_sym(ev_sym), .ev_sym_val(ev_sym_val), .sym_tick(sym_tick),
        .status(status), .irq(irq)
    );

    // mode = {tx, zp, psave, 4lvl}; ev = {sync, late, done, crc_bad, sym}
    typedef struct packed {
        logic       rd;
        logic       wr;
        logic [7:0] cmd;
        logic [3:0] mode;
        logic [4:0] ev;
        logic [1:0] sval;
        logic       tick;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 8'h00, 4'b0001, 5'b00000, 2'd0, 1'b0, 8'h00, 4'd9}, // R9 idle
        '{1'b0, 1'b1, 8'h80, 4'b0001, 5'b00000, 2'd0, 1'b0, 8'h00, 4'd3}, // R3 enable autosync
        '{1'b0, 1'b0, 8'h00, 4'b0001, 5'b10000, 2'd0, 1'b0, 8'hA0, 4'd3}, // R3 sync hit
        '{1'b1, 1'b0, 8'h00, 4'b0001, 5'b00000, 2'd0, 1'b0, 8'h00, 4'd3}, // R3 read clears
        '{1'b0, 1'b1, 8'h82, 4'b0001, 5'b00000, 2'd0, 1'b0, 8'h00, 4'd3}, // R3 search task
        '{1'b0, 1'b0, 8'h00, 4'b0001, 5'b10000, 2'd0, 1'b0, 8'h00, 4'd3}, // R3 sync in search ignored
        '{1'b0, 1'b0, 8'h00, 4'b0001, 5'b00110, 2'd0, 1'b0, 8'h08, 4'd5}, // R5 crc error
        '{1'b1, 1'b0, 8'h00, 4'b0001, 5'b00000, 2'd0, 1'b0, 8'h08, 4'd5}, // R5 survives read
        '{1'b0, 1'b0, 8'h00, 4'b0001, 5'b10000, 2'd0, 1'b0, 8'hA8, 4'd3}, // R3 search ended
        '{1'b1, 1'b0, 8'h00, 4'b0001, 5'b01000, 2'd0, 1'b0, 8'h98, 4'd8}, // R8 set beats read
        '{1'b1, 1'b0, 8'h00, 4'b0001, 5'b00000, 2'd0, 1'b0, 8'h08, 4'd4}, // R4 read clears ovf
        '{1'b0, 1'b0, 8'h00, 4'b0001, 5'b00001, 2'd2, 1'b0, 8'h0E, 4'd7}, // R7 4-level value
        '{1'b1, 1'b0, 8'h00, 4'b0001, 5'b00000, 2'd0, 1'b0, 8'h0A, 4'd6}, // R6 read clears ready
        '{1'b0, 1'b0, 8'h00, 4'b0000, 5'b00001, 2'd3, 1'b0, 8'h0D, 4'd7}, // R7 binary value
        '{1'b0, 1'b0, 8'h00, 4'b0000, 5'b00100, 2'd0, 1'b0, 8'h05, 4'd5}, // R5 crc good
        '{1'b0, 1'b1, 8'h01, 4'b0000, 5'b00000, 2'd0, 1'b0, 8'h01, 4'd5}, // R5 RESET flush
        '{1'b0, 1'b0, 8'h00, 4'b0000, 5'b10000, 2'd0, 1'b0, 8'h01, 4'd3}, // R3 autosync off
        '{1'b0, 1'b0, 8'h00, 4'b1000, 5'b00000, 2'd0, 1'b0, 8'h20, 4'd1}, // R1 to transmit
        '{1'b1, 1'b0, 8'h00, 4'b1000, 5'b00000, 2'd0, 1'b0, 8'h20, 4'd1}, // R1 read keeps
        '{1'b0, 1'b1, 8'h03, 4'b1000, 5'b00000, 2'd0, 1'b0, 8'h20, 4'd2}, // R2 work task
        '{1'b0, 1'b0, 8'h00, 4'b1000, 5'b00000, 2'd0, 1'b1, 8'h00, 4'd2}, // R2 tick clears
        '{1'b0, 1'b1, 8'h01, 4'b1000, 5'b00000, 2'd0, 1'b0, 8'h20, 4'd1}, // R1 RESET sets
        '{1'b0, 1'b1, 8'h00, 4'b1000, 5'b00000, 2'd0, 1'b0, 8'h20, 4'd2}, // R2 NULL write
        '{1'b0, 1'b0, 8'h00, 4'b1000, 5'b00000, 2'd0, 1'b1, 8'h20, 4'd2}, // R2 NULL no clear
        '{1'b0, 1'b0, 8'h00, 4'b1001, 5'b01111, 2'd3, 1'b0, 8'h24, 4'd4}, // R4 tx ignores late/done
        '{1'b1, 1'b0, 8'h00, 4'b1001, 5'b00000, 2'd0, 1'b0, 8'h20, 4'd6}, // R6 read in tx
        '{1'b0, 1'b1, 8'h04, 4'b1001, 5'b00000, 2'd0, 1'b1, 8'h20, 4'd2}, // R2 same-cycle tick
        '{1'b0, 1'b0, 8'h00, 4'b1001, 5'b00000, 2'd0, 1'b1, 8'h00, 4'd2}, // R2 next tick
        '{1'b0, 1'b0, 8'h00, 4'b1101, 5'b00000, 2'd0, 1'b0, 8'h20, 4'd1}, // R1 zero-power change
        '{1'b0, 1'b0, 8'h00, 4'b0001, 5'b00000, 2'd0, 1'b0, 8'h01, 4'd7}  // R7 value kept
    };

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic drive(logic rd, logic wr, logic [7:0] cmd, logic [3:0] m,
                         logic [4:0] ev, logic [1:0] sv, logic tk);
        host_rd = rd; cmd_wr = wr; cmd_data = cmd;
        {mode_tx, mode_zp, mode_psave, mode_4lvl} = m;
        {ev_sync, ev_late, ev_done, ev_crc_bad, ev_sym} = ev;
        ev_sym_val = sv; sym_tick = tk;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1;
        drive(0, 0, 8'h00, 4'b0001, 5'b0, 2'd0, 0);
        drive(0, 0, 8'h00, 4'b0001, 5'b0, 2'd0, 0);
        rst = 1'b0;
        check("R9 reset status rx", status, 8'h00);
        check("R9 reset irq", {7'd0, irq}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].rd, VECS[i].wr, VECS[i].cmd, VECS[i].mode,
                  VECS[i].ev, VECS[i].sval, VECS[i].tick);
            check($sformatf("R%0d vector %0d status", VECS[i].req, i), status, VECS[i].exp);
            check($sformatf("R8 vector %0d irq", i), {7'd0, irq}, {7'd0, VECS[i].exp[7]});
        end

        // R4: overflow in receive mode raises irq
        drive(0, 0, 8'h00, 4'b0001, 5'b01000, 2'd0, 0);
        check("R4 late sets ovf", status, 8'h91);
        // R6: symbol event wins over same-cycle read
        drive(1, 0, 8'h00, 4'b0001, 5'b00001, 2'd1, 0);
        check("R6 set beats read", status, 8'h05);
        // R9: reset while transmitting
        rst = 1'b1;
        drive(0, 0, 8'h00, 4'b1001, 5'b0, 2'd0, 0);
        drive(0, 0, 8'h00, 4'b1001, 5'b0, 2'd0, 0);
        rst = 1'b0;
        check("R9 reset status tx", status, 8'h20);
        // R2: a flush between task write and tick cancels the pending clear
        drive(0, 1, 8'h03, 4'b1001, 5'b0, 2'd0, 0);
        drive(0, 0, 8'h00, 4'b1011, 5'b0, 2'd0, 0);
        check("R1 power-save change", status, 8'h20);
        drive(0, 0, 8'h00, 4'b1011, 5'b0, 2'd0, 1);
        check("R2 pending clear cancelled", status, 8'h20);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule